// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

This block decides which of thirteen interrupt sources the processor core should service next. Each source has a pending flag, its own enable bit, and a two-bit priority level built from a high bit and a low bit. A global enable gates every source at once. Among the sources that are pending and enabled, the block picks the one at the highest level. If several share that level, a fixed ranking decides, and that ranking does not follow vector order. The block then presents the winner's vector address.

The block keeps a record of every level that has a handler running. When the core takes a vector, the granted level joins that record. When a handler returns, the most recent level leaves it. A new request reaches the core only if its level is strictly above the highest level already in service. A separate wake output tells power-management logic that a wake-capable source is pending and enabled, whatever the global enable holds.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, no level is in service. With no request pending, `irq_out` and `wake_out` are both 0.
- R2: A source is eligible only when its bit in `req_flags` and its bit in `src_en` are both 1. `irq_out` is 0 whenever `glob_en` is 0.
- R3: A source's level is {`prio_hi[k]`, `prio_lo[k]`}, where 3 is the highest. When eligible sources differ in level, the winner is at the highest level present.
- R4: Among eligible sources at the winning level, the winner is the first in this order: ext0, brownout, watchdog, timer0, I2C, ADC, ext1, keyboard, comparator1, timer1, comparator2, serial, timer I.
- R5: Bit k of every per-source vector maps to sources in this order, from k=0 to k=12: ext0, timer0, ext1, timer1, serial, brownout, I2C, keyboard, comparator2, watchdog, ADC, comparator1, timer I. The vectors are 0003h, 000Bh, 0013h, 001Bh, 0023h, 002Bh, 0033h, 003Bh, 0043h, 0053h, 005Bh, 0063h and 0073h, in that order. `vec_addr` shows the winner's vector.
- R6: While levels are in service, `irq_out` is 1 only if the winner's level is strictly above the highest in-service level. Once level 3 is in service, `irq_out` stays 0.
- R7: A `vec_ack` pulse while `irq_out` is 1 marks the winner's level as in service. A `vec_ack` pulse while `irq_out` is 0 has no effect.
- R8: A `reti` pulse removes the highest in-service level. A `reti` pulse with nothing in service has no effect. When `reti` and `vec_ack` arrive in the same cycle, only `reti` acts.
- R9: `wake_out` is 1 when an eligible source is one of ext0, ext1, brownout, keyboard, comparator2, watchdog, ADC or comparator1. This holds even when `glob_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_flags | input | 13 | Pending flag per source |
| src_en | input | 13 | Enable bit per source |
| prio_hi | input | 13 | Level high bit per source |
| prio_lo | input | 13 | Level low bit per source |
| glob_en | input | 1 | Global interrupt enable |
| vec_ack | input | 1 | Core takes the vector (one-cycle pulse) |
| reti | input | 1 | Handler return (one-cycle pulse) |
| irq_out | output | 1 | Interrupt request to the core |
| vec_addr | output | 16 | Vector of the winning source |
| wake_out | output | 1 | Wake request for power-down exit |

## Verification
The bench builds the block with its default parameters: thirteen sources and two level bits, so four levels. At this size every single source can be tried at every level. Every ordered pair of sources can be tried both tied at one level and split across two levels, so the whole ranking and vector table are covered. Nesting is driven through all four levels and unwound with returns, which brings every shape of the in-service record within reach, including the top-level lockout.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NSRC = 13;
  localparam int LW   = 2;
  localparam int NLVL = 1 << LW;
  localparam int VW   = 16;
  localparam int IW   = $clog2(NSRC);

  // sources that may end power-down: ext0, ext1, brownout, keyboard,
  // comparator2, watchdog, ADC, comparator1
  localparam logic [NSRC-1:0] WAKE_MASK = 13'h0FA5;

  // vectors step by 8 from 0003h with two gaps (before watchdog, before timer I)
  function automatic logic [VW-1:0] src_vector(input int unsigned idx);
    int unsigned v;
    if (idx <= 8)       v = 3 + idx * 8;
    else if (idx <= 11) v = 16'h0053 + (idx - 9) * 8;
    else                v = 16'h0073;
    return VW'(v);
  endfunction

  // tie-break position r (0 = first) -> source index
  function automatic int unsigned rank_to_src(input int unsigned r);
    case (r)
      0: return 0;   1: return 5;   2: return 9;   3: return 1;
      4: return 6;   5: return 10;  6: return 2;   7: return 7;
      8: return 11;  9: return 3;   10: return 8;  11: return 4;
      default: return 12;
    endcase
  endfunction

  // index of highest set bit; 0 when empty
  function automatic logic [LW-1:0] top_set(input logic [NLVL-1:0] m);
    logic [LW-1:0] t;
    t = '0;
    for (int i = 0; i < NLVL; i++) if (m[i]) t = LW'(i);
    return t;
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_nest_pkg::*;
(
  input  logic [NSRC-1:0]         elig,
  input  logic [NSRC-1:0][LW-1:0] lvl,
  output logic                    any,
  output logic [LW-1:0]           win_lvl,
  output logic [IW-1:0]           win_src
);
  logic [NLVL-1:0]         lvl_any;
  logic [NLVL-1:0][IW-1:0] lvl_idx;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    logic [NSRC-1:0] hit;
    logic [IW-1:0]   idx;
    always_comb begin
      for (int s = 0; s < NSRC; s++) hit[s] = elig[s] && (lvl[s] == LW'(l));
      idx = '0;
      for (int r = NSRC - 1; r >= 0; r--)
        if (hit[rank_to_src(r)]) idx = IW'(rank_to_src(r));
    end
    assign lvl_any[l] = |hit;
    assign lvl_idx[l] = idx;
  end

  always_comb begin
    win_lvl = '0;
    win_src = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (lvl_any[l]) begin
        win_lvl = LW'(l);
        win_src = lvl_idx[l];
      end
    end
  end
  assign any = |lvl_any;
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_nest_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant,
  input  logic [LW-1:0]   grant_lvl,
  input  logic            ret,
  output logic [NLVL-1:0] mask,
  output logic            active,
  output logic [LW-1:0]   cur_lvl
);
  logic [NLVL-1:0] mask_nx;

  assign active  = |mask;
  assign cur_lvl = top_set(mask);

  always_comb begin
    mask_nx = mask;
    if (ret) begin
      if (active) mask_nx[cur_lvl] = 1'b0;
    end else if (grant) begin
      mask_nx[grant_lvl] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_nx;
  end

  // R8
  ret_pops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && active) |=> ($countones(mask) == $countones($past(mask)) - 1));
  // R8
  ret_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !active) |=> (mask == '0));
  // R7
  grant_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !ret) |=> mask[$past(grant_lvl)]);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_flags,
  input  logic [NSRC-1:0]   src_en,
  input  logic [NSRC-1:0]   prio_hi,
  input  logic [NSRC-1:0]   prio_lo,
  input  logic              glob_en,
  input  logic              vec_ack,
  input  logic              reti,
  output logic              irq_out,
  output logic [VW-1:0]     vec_addr,
  output logic              wake_out
);
  logic [NSRC-1:0]         elig;
  logic [NSRC-1:0][LW-1:0] lvl;
  logic                    any_pend;
  logic [LW-1:0]           win_lvl;
  logic [IW-1:0]           win_src;
  logic [NLVL-1:0]         svc_mask;
  logic                    svc_active;
  logic [LW-1:0]           svc_lvl;
  logic                    preempt_ok;
  logic                    grant_ev;

  assign elig = req_flags & src_en;
  for (genvar s = 0; s < NSRC; s++) begin : g_lvl
    assign lvl[s] = {prio_hi[s], prio_lo[s]};
  end

  irq_pick u_pick (
    .elig    (elig),
    .lvl     (lvl),
    .any     (any_pend),
    .win_lvl (win_lvl),
    .win_src (win_src)
  );

  irq_inservice u_svc (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant_ev),
    .grant_lvl (win_lvl),
    .ret       (reti),
    .mask      (svc_mask),
    .active    (svc_active),
    .cur_lvl   (svc_lvl)
  );

  assign preempt_ok = !svc_active || (win_lvl > svc_lvl);
  assign irq_out    = glob_en && any_pend && preempt_ok;
  assign grant_ev   = vec_ack && irq_out;
  assign vec_addr   = src_vector(int'(win_src));
  assign wake_out   = |(elig & WAKE_MASK);

  // R2
  glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> glob_en);
  // R6
  strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && svc_active) |-> (win_lvl > svc_lvl));
  // R6
  top_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_mask[NLVL-1] |-> !irq_out);
  // R4
  winner_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> (elig[win_src] && lvl[win_src] == win_lvl));
  // R9
  wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_flags & src_en) == '0) |-> !wake_out);
  // R7
  ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && !irq_out && !reti) |=> (svc_mask == $past(svc_mask)));
endmodule

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
  localparam int N = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_flags, src_en, prio_hi, prio_lo;
  logic glob_en, vec_ack, reti;
  logic irq_out, wake_out;
  logic [15:0] vec_addr;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_nest_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_flags(req_flags), .src_en(src_en),
    .prio_hi(prio_hi), .prio_lo(prio_lo), .glob_en(glob_en),
    .vec_ack(vec_ack), .reti(reti), .irq_out(irq_out),
    .vec_addr(vec_addr), .wake_out(wake_out)
  );

  function automatic int ref_vec(input int s);
    case (s)
      0: return 'h03;  1: return 'h0B;  2: return 'h13;  3: return 'h1B;
      4: return 'h23;  5: return 'h2B;  6: return 'h33;  7: return 'h3B;
      8: return 'h43;  9: return 'h53;  10: return 'h5B; 11: return 'h63;
      default: return 'h73;
    endcase
  endfunction

  // smaller = preferred
  function automatic int ref_rank(input int s);
    case (s)
      0: return 1;  5: return 2;  9: return 3;  1: return 4;
      6: return 5;  10: return 6; 2: return 7;  7: return 8;
      11: return 9; 3: return 10; 8: return 11; 4: return 12;
      default: return 13;
    endcase
  endfunction

  function automatic bit ref_wake(input int s);
    return (s == 0 || s == 2 || s == 5 || s == 7 || s == 8 ||
            s == 9 || s == 10 || s == 11);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    req_flags = '0; src_en = '0; prio_hi = '0; prio_lo = '0;
    glob_en = 1'b0; vec_ack = 1'b0; reti = 1'b0;
  endtask

  task automatic raise(input int s, input int l);
    req_flags[s] = 1'b1; src_en[s] = 1'b1;
    prio_hi[s] = l[1]; prio_lo[s] = l[0];
  endtask

  task automatic pulse(input bit a, input bit r);
    @(negedge clk); vec_ack = a; reti = r;
    @(negedge clk); vec_ack = 1'b0; reti = 1'b0;
    #1;
  endtask

  // one request at level l, read irq
  task automatic probe(input string tag, input int s, input int l, input bit exp);
    @(negedge clk);
    req_flags = '0; src_en = '0; raise(s, l); glob_en = 1'b1;
    #1 chk(tag, int'(irq_out), int'(exp));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 irq after reset", int'(irq_out), 0);
    chk("R1 wake after reset", int'(wake_out), 0);

    // singles at every level
    for (int s = 0; s < N; s++) begin
      for (int l = 0; l < 4; l++) begin
        @(negedge clk); clr(); raise(s, l); glob_en = 1'b1;
        #1 chk("R5 single irq", int'(irq_out), 1);
        chk("R5 vector", int'(vec_addr), ref_vec(s));
      end
      @(negedge clk); clr(); raise(s, 1);
      #1 chk("R2 glob_en off", int'(irq_out), 0);
      chk("R9 wake ignores glob_en", int'(wake_out), int'(ref_wake(s)));
      glob_en = 1'b1; src_en[s] = 1'b0;
      #1 chk("R2 src disabled", int'(irq_out), 0);
      chk("R2 disabled no wake", int'(wake_out), 0);
    end

    // ties and level splits over all ordered pairs
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i != j) begin
          int a, b, w;
          @(negedge clk); clr(); glob_en = 1'b1;
          a = (i + j) % 4;
          raise(i, a); raise(j, a);
          w = (ref_rank(i) < ref_rank(j)) ? i : j;
          #1 chk("R4 same-level tie", int'(vec_addr), ref_vec(w));
          b = (a + 1 + (j % 3)) % 4;
          raise(j, b);
          w = (b > a) ? j : i;
          #1 chk("R3 higher level wins", int'(vec_addr), ref_vec(w));
        end
      end
    end

    // ack ignored while no request is shown
    @(negedge clk); clr(); raise(3, 2);
    pulse(1'b1, 1'b0);
    probe("R7 ack without irq ignored", 4, 0, 1);
    // reti and ack together: reti only
    @(negedge clk); clr(); raise(3, 1); glob_en = 1'b1;
    pulse(1'b1, 1'b1);
    probe("R8 reti beats ack", 4, 0, 1);

    // nest through all four levels
    probe("R6 level0 grant", 1, 0, 1);  pulse(1'b1, 1'b0);
    probe("R6 equal level blocked", 2, 0, 0);
    probe("R6 level1 preempts", 2, 1, 1); pulse(1'b1, 1'b0);
    probe("R6 level1 blocked at 1", 5, 1, 0);
    probe("R6 level2 preempts", 5, 2, 1); pulse(1'b1, 1'b0);
    probe("R6 level3 preempts", 9, 3, 1); pulse(1'b1, 1'b0);
    probe("R6 top level locked", 0, 3, 0);
    pulse(1'b0, 1'b1);
    probe("R8 after pop level3 again", 0, 3, 1);
    probe("R8 level2 still held", 0, 2, 0);
    pulse(1'b0, 1'b1);
    probe("R8 level2 freed", 0, 2, 1);
    probe("R8 level1 still held", 0, 1, 0);
    pulse(1'b0, 1'b1);
    probe("R8 level1 freed", 0, 1, 1);
    probe("R8 level0 still held", 0, 0, 0);
    pulse(1'b0, 1'b1);
    probe("R8 all freed", 0, 0, 1);
    pulse(1'b0, 1'b1);
    probe("R8 reti on empty", 6, 0, 1);
    @(negedge clk); clr(); #1;
    chk("R1 idle again", int'(irq_out), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule